// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps a small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Every line carries one of four coherence states: Invalid, Shared, Exclusive or Modified. The processor side takes one read or write at a time and answers with an acknowledge pulse, a hit flag and read data. The bus side does two jobs. It asks for the bus whenever the local request needs a transaction: a read, a read-for-ownership, an upgrade or a write-back of a dirty victim. It also watches the transactions of other cores and answers them with a copy-present flag, a data-supply flag, a write-to-memory flag and the line contents.

Bus arbitration sits outside the block. An external arbiter grants the bus for one cycle at a time. Snoops never fall in a grant cycle or in the response cycle that follows a grant. For a fill, the wired-OR shared-copy flag, the cache-to-cache data and the memory data all arrive one cycle after the grant. A snoop that reaches a line while a local request waits for the bus is applied first. The waiting request then works out its command again from the new state.

Top module: `mesi_coh_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `cpu_ready` is 1, and `cpu_ack`, `bus_req`, `snp_hit`, `snp_flush` and `snp_wb` are 0. Every line starts Invalid.
- R2: A read to a line held in Modified, Exclusive or Shared, with a matching tag, is acknowledged two cycles after the request cycle with `cpu_hit`=1 and the addressed word. No bus request is raised.
- R3: A read to an Invalid or tag-mismatched clean line requests the bus with command code 0 (read) and the line address {tag, index}. One cycle after the grant, the line fills. It becomes Shared if `bus_shared` is 1 and Exclusive if it is 0. The acknowledge follows one cycle after that, with `cpu_hit`=0.
- R4: A write that misses requests command code 1 (read-exclusive). The fetched line takes the write word at the addressed word position; word w occupies bits [w*DATA_W +: DATA_W]. The line ends Modified.
- R5: A write to a Shared line with a matching tag requests command code 2 (upgrade). It uses no fill data. The line becomes Modified and the acknowledge comes in the cycle after the grant, with `cpu_hit`=0.
- R6: A write to an Exclusive or Modified line is a hit with no bus request, and the line becomes Modified.
- R7: A snooped read (snoop code 0) to a present line gives responses in the next cycle. `snp_hit` is 1. An Exclusive or Modified line raises `snp_flush` with its data and moves to Shared, and a Modified line also raises `snp_wb`. A Shared line stays Shared and supplies data only when SHR_SUPPLY is 1 (default 0).
- R8: A snooped read-exclusive (code 1) to a present line sets `snp_hit` and moves the line to Invalid. Exclusive and Modified lines flush their data, and a Modified line also raises `snp_wb`.
- R9: A snooped upgrade (code 2) to a present Shared line sets `snp_hit`, supplies no data and moves the line to Invalid.
- R10: A snoop to an Invalid line or to a different tag, and any snoop carrying the write-back code 3, leaves every response at 0 and changes no line state.
- R11: During a fill, data offered by another cache (`bus_c2c_vld`=1) is used instead of the memory data.
- R12: A snoop to the line of a request waiting for the bus is applied before that request's command is chosen. A pending write to a Shared line that was invalidated in the meantime requests read-exclusive (code 1) instead of upgrade.
- R13: A miss whose victim is Modified first requests a write-back (code 3) with the victim's address {old tag, index} and its whole line on `bus_wdata`, and then the fill. A clean victim is dropped without a write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte-word address {tag, index, word} |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Controller idle, can take a request |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Request finished without a bus transaction |
| cpu_rdata | output | DATA_W | Addressed word after the access |
| bus_req | output | 1 | Bus wanted |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| bus_addr | output | ADDR_W-OFF_W | Line address {tag, index} |
| bus_wdata | output | LINE_W | Victim line for write-back, else 0 |
| bus_gnt | input | 1 | One-cycle grant of the presented command |
| bus_shared | input | 1 | Wired-OR copy-present flag, cycle after grant |
| bus_c2c_vld | input | 1 | Another cache supplies the fill, cycle after grant |
| bus_c2c_data | input | LINE_W | Cache-to-cache fill line |
| bus_mem_data | input | LINE_W | Memory fill line |
| snp_vld | input | 1 | Another core's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same codes as `bus_cmd` |
| snp_addr | input | ADDR_W-OFF_W | Snooped line address |
| snp_hit | output | 1 | This cache held a valid copy |
| snp_flush | output | 1 | This cache drives the line on the bus |
| snp_wb | output | 1 | Flushed data is dirty and must be written to memory |
| snp_data | output | LINE_W | Flushed line, 0 when not flushing |

## Verification
A line in the wrong state stays hidden inside the arrays. It comes out at the ports at the next access to that line. A snoop shows it one cycle later, through the hit, flush and write-back flags and the flushed data. A local access shows it through `cpu_hit`, the command the controller puts on the bus, and the acknowledge timing. The bench therefore steers each line through its states with local accesses and then probes it with snoops. A wrongly kept, promoted or dropped state then appears within one or two cycles of the probe. A mis-merged word or a wrong fill source shows in `cpu_rdata` on the acknowledge, and later in the data flushed to a snoop.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_RDX = 2'd1,
    BC_UPG = 2'd2,
    BC_WB  = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_LOOK = 2'd1,
    F_REQ  = 2'd2,
    F_RESP = 2'd3
  } seq_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 5,
  parameter int LINE_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  // port A: local request side
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [LINE_W-1:0] a_data,
  input  logic              f_st_we,
  input  line_st_t          f_st,
  input  logic              f_tag_we,
  input  logic [TAG_W-1:0]  f_tag,
  input  logic              f_dat_we,
  input  logic [LINE_W-1:0] f_dat,
  // port B: snoop side
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [LINE_W-1:0] b_data,
  input  logic              s_we,
  input  line_st_t          s_st
);
  line_st_t          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [LINE_W-1:0] mem   [LINES];

  // state and tag: small flop arrays, local writer wins a tie
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (f_st_we && a_idx == IDX_W'(i))
          st_q[i] <= f_st;
        else if (s_we && b_idx == IDX_W'(i))
          st_q[i] <= s_st;
        if (f_tag_we && a_idx == IDX_W'(i))
          tag_q[i] <= f_tag;
      end
    end
  end

  // line data: single write port, two asynchronous reads (distributed RAM)
  always_ff @(posedge clk) begin
    if (f_dat_we) mem[a_idx] <= f_dat;
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = mem[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = mem[b_idx];

  AST_ONE_WRITER_PER_LINE: assert property (@(posedge clk) disable iff (rst)
    !(f_st_we && s_we && a_idx == b_idx)) else $error("two state writers on one line"); // R12
endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop
  import mesi_pkg::*;
#(
  parameter int TAG_W      = 5,
  parameter int LINE_W     = 16,
  parameter bit SHR_SUPPLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_vld,
  input  bus_cmd_t          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_t          l_st,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic [LINE_W-1:0] l_data,
  output logic              s_we,
  output line_st_t          s_st,
  output logic              rsp_hit,
  output logic              rsp_flush,
  output logic              rsp_wb,
  output logic [LINE_W-1:0] rsp_data
);
  logic present, act, give, dirty;

  assign present = (l_st != ST_I) && (l_tag == snp_tag);
  assign act     = snp_vld && present && (snp_cmd != BC_WB);

  always_comb begin
    s_st  = l_st;
    give  = 1'b0;
    dirty = 1'b0;
    unique case (snp_cmd)
      BC_RD: begin
        s_st  = ST_S;
        give  = (l_st == ST_E) || (l_st == ST_M) || ((l_st == ST_S) && SHR_SUPPLY);
        dirty = (l_st == ST_M);
      end
      BC_RDX: begin
        s_st  = ST_I;
        give  = (l_st == ST_E) || (l_st == ST_M) || ((l_st == ST_S) && SHR_SUPPLY);
        dirty = (l_st == ST_M);
      end
      BC_UPG: s_st = ST_I;
      default: s_st = l_st;
    endcase
  end

  assign s_we = act;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_hit   <= 1'b0;
      rsp_flush <= 1'b0;
      rsp_wb    <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_hit   <= act;
      rsp_flush <= act && give;
      rsp_wb    <= act && dirty;
      rsp_data  <= (act && give) ? l_data : '0;
    end
  end

  AST_WB_NEEDS_FLUSH: assert property (@(posedge clk) disable iff (rst)
    rsp_wb |-> rsp_flush) else $error("dirty response without data"); // R7
  AST_FLUSH_NEEDS_COPY: assert property (@(posedge clk) disable iff (rst)
    rsp_flush |-> rsp_hit) else $error("data supplied without a copy"); // R8
  AST_UPG_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (snp_vld && snp_cmd == BC_UPG) |=> !rsp_flush) else $error("upgrade snoop supplied data"); // R9
  AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (rst)
    (snp_vld && l_st == ST_I) |=> !rsp_hit) else $error("invalid line answered"); // R10
endmodule

// File: rtl/mesi_coh_ctrl.sv
module mesi_coh_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int LINE_WORDS = 2,
  parameter int LINES      = 4,
  parameter bit SHR_SUPPLY = 1'b0,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = DATA_W * LINE_WORDS,
  localparam int LA_W   = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_ack,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [LA_W-1:0]   bus_addr,
  output logic [LINE_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  input  logic              bus_c2c_vld,
  input  logic [LINE_W-1:0] bus_c2c_data,
  input  logic [LINE_W-1:0] bus_mem_data,
  input  logic              snp_vld,
  input  logic [1:0]        snp_cmd,
  input  logic [LA_W-1:0]   snp_addr,
  output logic              snp_hit,
  output logic              snp_flush,
  output logic              snp_wb,
  output logic [LINE_W-1:0] snp_data
);
  function automatic logic [DATA_W-1:0] get_word(input logic [LINE_W-1:0] l,
                                                 input logic [OFF_W-1:0] o);
    get_word = '0;
    for (int w = 0; w < LINE_WORDS; w++)
      if (o == OFF_W'(w)) get_word = l[w*DATA_W +: DATA_W];
  endfunction

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l,
                                                 input logic [OFF_W-1:0] o,
                                                 input logic [DATA_W-1:0] d);
    put_word = l;
    for (int w = 0; w < LINE_WORDS; w++)
      if (o == OFF_W'(w)) put_word[w*DATA_W +: DATA_W] = d;
  endfunction

  seq_t              seq_q;
  logic              rq_we;
  logic [TAG_W-1:0]  rq_tag;
  logic [IDX_W-1:0]  rq_idx;
  logic [OFF_W-1:0]  rq_off;
  logic [DATA_W-1:0] rq_wdata;

  line_st_t          a_st, b_st, s_st, f_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [LINE_W-1:0] a_data, b_data, f_dat, fill_src, fill_line;
  logic              f_st_we, f_tag_we, f_dat_we, s_we;
  logic              a_present, snp_same, local_hit;
  bus_cmd_t          cmd_c;
  bus_cmd_t          snp_cmd_t;
  logic [TAG_W-1:0]  snp_tag;
  logic [IDX_W-1:0]  snp_idx;

  assign snp_cmd_t = bus_cmd_t'(snp_cmd);
  assign snp_tag   = snp_addr[LA_W-1 -: TAG_W];
  assign snp_idx   = snp_addr[IDX_W-1:0];

  mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst(rst),
    .a_idx(rq_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .f_st_we(f_st_we), .f_st(f_st), .f_tag_we(f_tag_we), .f_tag(rq_tag),
    .f_dat_we(f_dat_we), .f_dat(f_dat),
    .b_idx(snp_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .s_we(s_we), .s_st(s_st)
  );

  mesi_snoop #(.TAG_W(TAG_W), .LINE_W(LINE_W), .SHR_SUPPLY(SHR_SUPPLY)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_vld(snp_vld), .snp_cmd(snp_cmd_t), .snp_tag(snp_tag),
    .l_st(b_st), .l_tag(b_tag), .l_data(b_data),
    .s_we(s_we), .s_st(s_st),
    .rsp_hit(snp_hit), .rsp_flush(snp_flush), .rsp_wb(snp_wb), .rsp_data(snp_data)
  );

  // lookup of the pending request against the current (post-snoop) line
  assign a_present = (a_st != ST_I) && (a_tag == rq_tag);
  assign local_hit = a_present && (!rq_we || a_st != ST_S);
  assign snp_same  = snp_vld && (snp_idx == rq_idx);

  // command chosen afresh every cycle from the live line state
  always_comb begin
    if (a_st == ST_M && a_tag != rq_tag)  cmd_c = BC_WB;
    else if (a_present && rq_we)          cmd_c = BC_UPG;
    else if (rq_we)                       cmd_c = BC_RDX;
    else                                  cmd_c = BC_RD;
  end

  assign fill_src  = bus_c2c_vld ? bus_c2c_data : bus_mem_data;
  assign fill_line = rq_we ? put_word(fill_src, rq_off, rq_wdata) : fill_src;

  assign cpu_ready = (seq_q == F_IDLE);
  assign bus_req   = (seq_q == F_REQ);
  assign bus_cmd   = cmd_c;
  assign bus_addr  = (cmd_c == BC_WB) ? {a_tag, rq_idx} : {rq_tag, rq_idx};
  assign bus_wdata = (bus_req && cmd_c == BC_WB) ? a_data : '0;

  // array write controls
  always_comb begin
    f_st_we  = 1'b0;
    f_st     = a_st;
    f_tag_we = 1'b0;
    f_dat_we = 1'b0;
    f_dat    = put_word(a_data, rq_off, rq_wdata);
    unique case (seq_q)
      F_LOOK: if (!snp_same && local_hit && rq_we) begin
        f_st_we  = 1'b1;
        f_st     = ST_M;
        f_dat_we = 1'b1;
      end
      F_REQ: if (bus_gnt) begin
        if (cmd_c == BC_WB) begin
          f_st_we = 1'b1;
          f_st    = ST_I;
        end else if (cmd_c == BC_UPG) begin
          f_st_we  = 1'b1;
          f_st     = ST_M;
          f_dat_we = 1'b1;
        end
      end
      F_RESP: begin
        f_st_we  = 1'b1;
        f_st     = rq_we ? ST_M : (bus_shared ? ST_S : ST_E);
        f_tag_we = 1'b1;
        f_dat_we = 1'b1;
        f_dat    = fill_line;
      end
      default: ;
    endcase
  end

  // request sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q     <= F_IDLE;
      rq_we     <= 1'b0;
      rq_tag    <= '0;
      rq_idx    <= '0;
      rq_off    <= '0;
      rq_wdata  <= '0;
      cpu_ack   <= 1'b0;
      cpu_hit   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ack <= 1'b0;
      unique case (seq_q)
        F_IDLE: if (cpu_req) begin
          rq_we    <= cpu_we;
          rq_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
          rq_idx   <= cpu_addr[OFF_W +: IDX_W];
          rq_off   <= cpu_addr[OFF_W-1:0];
          rq_wdata <= cpu_wdata;
          seq_q    <= F_LOOK;
        end
        F_LOOK: if (!snp_same) begin
          if (local_hit) begin
            cpu_ack   <= 1'b1;
            cpu_hit   <= 1'b1;
            cpu_rdata <= rq_we ? rq_wdata : get_word(a_data, rq_off);
            seq_q     <= F_IDLE;
          end else begin
            seq_q <= F_REQ;
          end
        end
        F_REQ: if (bus_gnt) begin
          if (cmd_c == BC_UPG) begin
            cpu_ack   <= 1'b1;
            cpu_hit   <= 1'b0;
            cpu_rdata <= rq_wdata;
            seq_q     <= F_IDLE;
          end else if (cmd_c != BC_WB) begin
            seq_q <= F_RESP;
          end
        end
        F_RESP: begin
          cpu_ack   <= 1'b1;
          cpu_hit   <= 1'b0;
          cpu_rdata <= get_word(fill_line, rq_off);
          seq_q     <= F_IDLE;
        end
        default: seq_q <= F_IDLE;
      endcase
    end
  end

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack) else $error("acknowledge longer than a cycle"); // R2
  AST_UPG_ACKS_NEXT: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_cmd == 2'd2) |=> (cpu_ack && !cpu_hit)) else $error("upgrade not finished"); // R5
  AST_FILL_ACKS_LATER: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_cmd[1] == 1'b0) |=> !cpu_ack ##1 (cpu_ack && !cpu_hit)) else $error("fill timing"); // R3
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_cmd == 2'd3) |=> (bus_req && bus_cmd != 2'd3)) else $error("no fill after write-back"); // R13
  AST_NO_SNOOP_IN_GRANT: assert property (@(posedge clk) disable iff (rst)
    !(bus_gnt && snp_vld)) else $error("snoop during own grant"); // R12
endmodule

// File: tb/mesi_coh_ctrl_bench.sv
module mesi_coh_ctrl_bench;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int WORDS  = 2;
  localparam int LINES  = 4;
  localparam bit SUP    = 1'b0;
  localparam int OFF_W  = 1;
  localparam int IDX_W  = 2;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int LA_W   = ADDR_W - OFF_W;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ready, cpu_ack, cpu_hit;
  logic [DATA_W-1:0] cpu_rdata;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [LA_W-1:0] bus_addr;
  logic [LINE_W-1:0] bus_wdata;
  logic bus_gnt = 0, bus_shared = 0, bus_c2c_vld = 0;
  logic [LINE_W-1:0] bus_c2c_data = '0, bus_mem_data = '0;
  logic snp_vld = 0;
  logic [1:0] snp_cmd = '0;
  logic [LA_W-1:0] snp_addr = '0;
  logic snp_hit, snp_flush, snp_wb;
  logic [LINE_W-1:0] snp_data;

  always #(CLK_P/2) clk = ~clk;

  mesi_coh_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(WORDS),
                  .LINES(LINES), .SHR_SUPPLY(SUP)) u_mesi_coh_ctrl (.*);

  // behavioural reference: 0=I 1=S 2=E 3=M
  int                mst  [LINES];
  logic [TAG_W-1:0]  mtag [LINES];
  logic [LINE_W-1:0] mdat [LINES];
  int total = 0, bad = 0;
  bit finished = 0;

  bit exp_on = 0, e_hit, e_fl, e_wb;
  logic [LINE_W-1:0] e_dat;
  string e_req;

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", r, what, act, exp);
    end
  endtask

  // snoop responses compared every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (!rst) begin
      if (exp_on) begin
        chk(e_req, "snp_hit", 32'(snp_hit), 32'(e_hit));
        chk(e_req, "snp_flush", 32'(snp_flush), 32'(e_fl));
        chk(e_req, "snp_wb", 32'(snp_wb), 32'(e_wb));
        chk(e_req, "snp_data", 32'(snp_data), 32'(e_dat));
        exp_on = 0;
      end else if (snp_hit || snp_flush || snp_wb) begin
        chk("R10", "idle snoop response", {29'd0, snp_hit, snp_flush, snp_wb}, 32'd0);
      end
    end
  end

  function automatic logic [DATA_W-1:0] wget(input logic [LINE_W-1:0] l, input logic o);
    return o ? l[2*DATA_W-1:DATA_W] : l[DATA_W-1:0];
  endfunction
  function automatic logic [LINE_W-1:0] wput(input logic [LINE_W-1:0] l, input logic o, input logic [DATA_W-1:0] d);
    logic [LINE_W-1:0] r = l;
    if (o) r[2*DATA_W-1:DATA_W] = d; else r[DATA_W-1:0] = d;
    return r;
  endfunction

  // apply a snoop to the model and set expected responses
  task automatic model_snoop(input logic [1:0] c, input logic [LA_W-1:0] la, input string r);
    int i = int'(la[IDX_W-1:0]);
    bit pres = (mst[i] != 0) && (mtag[i] == la[LA_W-1 -: TAG_W]) && (c != 2'd3);
    e_req = r; e_hit = pres; e_fl = 0; e_wb = 0; e_dat = '0;
    if (pres) begin
      if (c != 2'd2) begin
        e_fl = (mst[i] >= 2) || (mst[i] == 1 && SUP);
        e_wb = (mst[i] == 3);
        if (e_fl) e_dat = mdat[i];
      end
      mst[i] = (c == 2'd0) ? 1 : 0;
    end
    exp_on = 1;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [LA_W-1:0] la, input string r);
    @(negedge clk);
    snp_vld = 1; snp_cmd = c; snp_addr = la;
    model_snoop(c, la, r);
    @(negedge clk);
    snp_vld = 0;
  endtask

  task automatic cpu_op(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        input bit sh, input bit cv, input logic [LINE_W-1:0] cd,
                        input logic [LINE_W-1:0] md, input bit inj, input logic [1:0] ic,
                        input string r);
    int i = int'(a[OFF_W +: IDX_W]);
    logic [TAG_W-1:0] tg = a[ADDR_W-1 -: TAG_W];
    logic o = a[0];
    bit exp_hit, done = 0, fill_next = 0;
    logic [DATA_W-1:0] exp_rd = '0;
    logic [1:0] ec;
    exp_hit = (mst[i] != 0) && (mtag[i] == tg) && (!we || mst[i] != 1);
    if (exp_hit) begin
      if (we) begin mdat[i] = wput(mdat[i], o, wd); mst[i] = 3; exp_rd = wd; end
      else exp_rd = wget(mdat[i], o);
    end
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 0;
    for (int n = 0; n < 40 && !done; n++) begin
      bus_gnt = 0; bus_c2c_vld = 0; bus_shared = 0; snp_vld = 0;
      if (cpu_ack) begin
        chk(r, "cpu_hit", 32'(cpu_hit), 32'(exp_hit));
        chk(r, "cpu_rdata", 32'(cpu_rdata), 32'(exp_rd));
        done = 1;
      end else if (fill_next) begin
        bus_shared = sh; bus_c2c_vld = cv; bus_c2c_data = cd; bus_mem_data = md;
        mdat[i] = cv ? cd : md;
        if (we) mdat[i] = wput(mdat[i], o, wd);
        mst[i] = we ? 3 : (sh ? 1 : 2);
        mtag[i] = tg;
        exp_rd = wget(mdat[i], o);
        fill_next = 0;
      end else if (bus_req) begin
        if (exp_hit) chk(r, "bus_req on hit", 32'd1, 32'd0);
        if (inj) begin
          inj = 0;
          snp_vld = 1; snp_cmd = ic; snp_addr = {tg, a[OFF_W +: IDX_W]};
          model_snoop(ic, {tg, a[OFF_W +: IDX_W]}, r);
        end else begin
          if (mst[i] == 3 && mtag[i] != tg) ec = 2'd3;
          else if (mst[i] == 1 && mtag[i] == tg && we) ec = 2'd2;
          else if (we) ec = 2'd1;
          else ec = 2'd0;
          chk(r, "bus_cmd", 32'(bus_cmd), 32'(ec));
          if (ec == 2'd3) begin
            chk(r, "wb addr", 32'(bus_addr), 32'({mtag[i], a[OFF_W +: IDX_W]}));
            chk(r, "wb data", 32'(bus_wdata), 32'(mdat[i]));
            mst[i] = 0;
          end else begin
            chk(r, "bus_addr", 32'(bus_addr), 32'({tg, a[OFF_W +: IDX_W]}));
            if (ec == 2'd2) begin
              mdat[i] = wput(mdat[i], o, wd); mst[i] = 3; exp_rd = wd;
            end else fill_next = 1;
          end
          bus_gnt = 1;
        end
      end
      if (!done) @(negedge clk);
    end
    if (!done) chk(r, "no acknowledge", 32'd0, 32'd1);
  endtask

  initial begin
    #(CLK_P*20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin mst[i] = 0; mtag[i] = '0; mdat[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", 32'(cpu_ready), 32'd1);
    rst = 0;
    @(negedge clk);
    chk("R1", "ready", 32'(cpu_ready), 32'd1);
    chk("R1", "ack/req/snoop", {28'd0, cpu_ack, bus_req, snp_hit, snp_flush | snp_wb}, 32'd0);

    // R3: read miss, no sharer -> Exclusive
    cpu_op(0, 8'h10, 0, 0, 0, 0, 16'hBEEF, 0, 0, "R3");
    // R2: read hit, upper word
    cpu_op(0, 8'h11, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R7: snoop read on Exclusive -> flush, Shared
    snoop(2'd0, 7'h08, "R7");
    // R5: write to Shared -> upgrade
    cpu_op(1, 8'h10, 8'h55, 0, 0, 0, 16'hDEAD, 0, 0, "R5");
    // R7: snoop read on Modified -> flush with write-back
    snoop(2'd0, 7'h08, "R7");
    // R8: snoop read-exclusive on Shared -> Invalid, no data
    snoop(2'd1, 7'h08, "R8");
    // R10: line now Invalid
    snoop(2'd0, 7'h08, "R10");
    // R4: write miss -> read-exclusive with merge
    cpu_op(1, 8'h22, 8'hAA, 1, 0, 0, 16'h1234, 0, 0, "R4");
    // R10: write-back code and tag mismatch are ignored
    snoop(2'd3, 7'h11, "R10");
    snoop(2'd0, 7'h21, "R10");
    // R13 + R11: dirty victim written back, fill from another cache, shared
    cpu_op(0, 8'h63, 0, 1, 1, 16'h7788, 16'h1111, 0, 0, "R13");
    cpu_op(0, 8'h62, 0, 0, 0, 0, 0, 0, 0, "R11");
    // R6: Exclusive promoted silently on write
    cpu_op(0, 8'h04, 0, 0, 0, 0, 16'h4321, 0, 0, "R3");
    cpu_op(1, 8'h05, 8'h99, 0, 0, 0, 0, 0, 0, "R6");
    snoop(2'd1, 7'h02, "R8");
    // R13: clean victim dropped without write-back
    cpu_op(0, 8'h06, 0, 0, 0, 0, 16'hA0A1, 0, 0, "R13");
    cpu_op(0, 8'h26, 0, 0, 0, 0, 16'hB0B1, 0, 0, "R13");
    // R12: Shared line invalidated while the upgrade waits -> read-exclusive
    cpu_op(1, 8'h62, 8'h3C, 0, 0, 0, 16'h9999, 1, 2'd1, "R12");
    cpu_op(0, 8'h63, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R9: upgrade snoop invalidates a Shared copy
    snoop(2'd0, 7'h13, "R7");
    snoop(2'd2, 7'h13, "R9");
    snoop(2'd0, 7'h13, "R9");
    repeat (3) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule